// File: doc/BRIEF.md
# Programmable Neighbourhood Edge Logic Cell

This block is the processing element for one pixel position in an array of identical elements. For each pixel it takes the grey-scale values of the eight surrounding pixels and gives a one-bit edge decision. A 1 marks the centre pixel as an edge and a 0 marks it as a non-edge. The decision comes from a complete binary logic tree of depth four, which has 15 gate nodes and 16 leaves. Each gate node runs one operation from a four-entry set. Each leaf picks a single bit from one of the three most significant bits of one neighbour.

The shape of the tree is loaded as a 110-bit genotype string on a serial port while a load enable is high. An external search process produces these strings. The tree that is already active keeps evaluating pixels during the shift. The new string takes over only once the load enable has fallen. The gate path from neighbour bits to the tree result is purely combinational. The result is registered once, so each pixel gives its decision one clock after it is presented.

Top module: `edge_logic_cell`

## Requirements
- R1: Gate node opcodes are 2-bit: 00 gives AND of the two children, 01 gives OR, 10 gives NOT of the left child (the right child is ignored), and 11 gives XOR.
- R2: Nodes are numbered in breadth-first order with node 0 at the root. Node k has left child 2k+1 and right child 2k+2. The children of nodes 7 to 14 are leaves: node 7 takes leaves 0 and 1, and node 14 takes leaves 14 and 15. The tree result is the output of node 0.
- R3: A leaf index is 5 bits. Bits [2:0] pick the neighbour: 0 N, 1 NE, 2 E, 3 SE, 4 S, 5 SW, 6 W, 7 NW. Neighbour n sits on nbPix[8n+7:8n]. Bits [4:3] hold a selector s, and the leaf reads pixel bit 5 + (s mod 3).
- R4: While loadEn is high, one loadBit enters per clock, least significant genotype bit first. Bits 2k+1:2k hold the opcode of node k. Bits 30+5j+4:30+5j hold the index of leaf j. When more than 110 bits are shifted, only the last 110 are kept.
- R5: Pixels sampled at the first rising edge with loadEn low after a load are still evaluated with the previous tree. Pixels sampled from the next edge onward use the new tree.
- R6: A pixel sampled with validIn high appears on edgeOut one clock later, with validOut high in that same cycle.
- R7: A clock with validIn low drives validOut low for the next cycle and leaves edgeOut unchanged.
- R8: A synchronous reset drives both outputs low and clears the genotype to zeros. The resulting tree is the AND of the N pixel's bit 5 with itself, so the edge decision equals nbPix[5].
- R9: Pixels keep being evaluated while a genotype is being shifted in, and they use the tree that is currently active.
- R10: A selector s of 3 picks the same bit as s of 0, which is pixel bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Genotype shift enable |
| loadBit | input | 1 | Serial genotype data, least significant bit first |
| validIn | input | 1 | Marks nbPix as a pixel to evaluate |
| nbPix | input | 64 | Eight neighbour pixels, N in bits 7:0 up to NW in bits 63:56 |
| edgeOut | output | 1 | Registered edge decision |
| validOut | output | 1 | Marks edgeOut as fresh |

## Verification
Four properties are checked on every cycle. The first is the one-cycle valid latency. The second is the hold of edgeOut on idle cycles. The third is the cleared outputs after reset. The fourth is that pixels still flow while a genotype is being shifted. The value of the decision itself can only be checked by the bench scenarios. These scenarios cover the opcode meanings, the leaf and node layout of the genotype, the selector wrap, and the exact cycle at which a newly shifted tree replaces the old one. A bench-side model of the tree, built from the requirements, is compared against random genotypes and pixels.

// File: rtl/edge_cell_pkg.sv
package edge_cell_pkg;
  localparam int NUM_NB     = 8;
  localparam int PIX_W      = 8;
  localparam int TERM_BITS  = 3;
  localparam int TREE_DEPTH = 4;
  localparam int OP_W       = 2;

  localparam int NB_SEL_W  = $clog2(NUM_NB);
  localparam int BIT_SEL_W = $clog2(TERM_BITS);
  localparam int LEAF_W    = NB_SEL_W + BIT_SEL_W;
  localparam int LEAVES    = 2 ** TREE_DEPTH;
  localparam int NODES     = LEAVES - 1;
  localparam int HEAP_N    = NODES + LEAVES;
  localparam int OPS_W     = NODES * OP_W;
  localparam int GENO_W    = OPS_W + LEAVES * LEAF_W;
  localparam int NBPIX_W   = NUM_NB * PIX_W;
  localparam int POS_W     = $clog2(NBPIX_W);
  localparam int TERM_BASE = PIX_W - TERM_BITS;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_NOT = 2'b10,
    OP_XOR = 2'b11
  } gateOp_t;

  typedef struct packed {
    logic shiftEn;
    logic commit;
    logic capture;
  } cellStrobe_t;

  function automatic logic applyOp(input logic [OP_W-1:0] op, input logic a, input logic b);
    case (gateOp_t'(op))
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_NOT:  return ~a;
      default: return a ^ b;
    endcase
  endfunction
endpackage

// File: rtl/edge_cell_ctrl.sv
module edge_cell_ctrl
  import edge_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        loadEn,
  input  logic        validIn,
  output cellStrobe_t strobe
);
  logic loadEnQ;

  always_ff @(posedge clk) begin
    if (rst) loadEnQ <= 1'b0;
    else     loadEnQ <= loadEn;
  end

  always_comb begin
    strobe.shiftEn = loadEn;
    strobe.commit  = loadEnQ & ~loadEn;
    strobe.capture = validIn;
  end
endmodule

// File: rtl/edge_cell_dp.sv
module edge_cell_dp
  import edge_cell_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  cellStrobe_t        strobe,
  input  logic               loadBit,
  input  logic [NBPIX_W-1:0] nbPix,
  output logic               edgeOut,
  output logic               validOut
);
  logic [GENO_W-1:0] shadowGeno;
  logic [GENO_W-1:0] activeGeno;
  logic [HEAP_N-1:0] heap;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowGeno <= '0;
      activeGeno <= '0;
    end else begin
      if (strobe.shiftEn) shadowGeno <= {loadBit, shadowGeno[GENO_W-1:1]};
      if (strobe.commit)  activeGeno <= shadowGeno;
    end
  end

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    logic [LEAF_W-1:0]    leafIdx;
    logic [NB_SEL_W-1:0]  nbSel;
    logic [BIT_SEL_W-1:0] bitSel;
    logic [POS_W-1:0]     pos;
    assign leafIdx = activeGeno[OPS_W + j*LEAF_W +: LEAF_W];
    assign nbSel   = leafIdx[NB_SEL_W-1:0];
    assign bitSel  = leafIdx[LEAF_W-1 -: BIT_SEL_W] % BIT_SEL_W'(TERM_BITS);
    assign pos     = POS_W'(nbSel) * POS_W'(PIX_W) + POS_W'(TERM_BASE) + POS_W'(bitSel);
    assign heap[NODES + j] = nbPix[pos];
  end

  for (genvar k = 0; k < NODES; k++) begin : g_node
    assign heap[k] = applyOp(activeGeno[k*OP_W +: OP_W], heap[2*k+1], heap[2*k+2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeOut  <= 1'b0;
      validOut <= 1'b0;
    end else begin
      validOut <= strobe.capture;
      if (strobe.capture) edgeOut <= heap[0];
    end
  end
endmodule

// File: rtl/edge_logic_cell.sv
module edge_logic_cell
  import edge_cell_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadBit,
  input  logic               validIn,
  input  logic [NBPIX_W-1:0] nbPix,
  output logic               edgeOut,
  output logic               validOut
);
  cellStrobe_t strobe;

  edge_cell_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadEn  (loadEn),
    .validIn (validIn),
    .strobe  (strobe)
  );

  edge_cell_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .loadBit  (loadBit),
    .nbPix    (nbPix),
    .edgeOut  (edgeOut),
    .validOut (validOut)
  );
endmodule

// File: rtl/edge_logic_cell_chk.sv
module edge_logic_cell_chk (
  input logic clk,
  input logic rst,
  input logic loadEn,
  input logic validIn,
  input logic edgeOut,
  input logic validOut
);
  // R6: a sampled pixel is flagged exactly one clock later
  p_valid_lat_r6: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);

  // R7: an idle clock clears the flag and holds the decision
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> (!validOut && $stable(edgeOut)));

  // R8: reset clears both outputs on the following edge
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!validOut && !edgeOut));

  // R9: pixels keep flowing during a genotype shift
  p_load_flow_r9: assert property (@(posedge clk) disable iff (rst)
    (loadEn && validIn) |=> validOut);
endmodule

bind edge_logic_cell edge_logic_cell_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .loadEn   (loadEn),
  .validIn  (validIn),
  .edgeOut  (edgeOut),
  .validOut (validOut)
);

// File: tb/tb_edge_logic_cell.sv
module tb_edge_logic_cell;
  localparam int GW = 110;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadBit = 1'b0;
  logic        validIn = 1'b0;
  logic [63:0] nbPix = '0;
  logic        edgeOut;
  logic        validOut;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  edge_logic_cell dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadBit(loadBit),
    .validIn(validIn), .nbPix(nbPix), .edgeOut(edgeOut), .validOut(validOut)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [31:0] xs(input logic [31:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Model built from R1, R2, R3, R10
  function automatic logic refTree(input logic [GW-1:0] g, input logic [63:0] px);
    logic [30:0] v;
    for (int j = 0; j < 16; j++) begin
      logic [4:0] idx;
      int n, s;
      idx = g[30 + 5*j +: 5];
      n = int'(idx[2:0]);
      s = int'(idx[4:3]) % 3;
      v[15 + j] = px[8*n + 5 + s];
    end
    for (int k = 14; k >= 0; k--) begin
      case (g[2*k +: 2])
        2'b00: v[k] = v[2*k+1] & v[2*k+2];
        2'b01: v[k] = v[2*k+1] | v[2*k+2];
        2'b10: v[k] = ~v[2*k+1];
        default: v[k] = v[2*k+1] ^ v[2*k+2];
      endcase
    end
    return v[0];
  endfunction

  function automatic logic [GW-1:0] mkGeno(input logic [1:0] op, input logic [4:0] leaf);
    logic [GW-1:0] g;
    for (int k = 0; k < 15; k++) g[2*k +: 2] = op;
    for (int j = 0; j < 16; j++) g[30 + 5*j +: 5] = leaf;
    return g;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic loadGeno(input logic [GW-1:0] g);
    for (int i = 0; i < GW; i++) begin
      @(negedge clk); loadEn = 1'b1; loadBit = g[i];
    end
    @(negedge clk); loadEn = 1'b0; loadBit = 1'b0;
  endtask

  task automatic sendPix(input logic [63:0] px, input logic [GW-1:0] g, input string req);
    @(negedge clk); validIn = 1'b1; nbPix = px;
    @(negedge clk); validIn = 1'b0;
    chk(req, edgeOut, refTree(g, px));
    chk(req, validOut, 1'b1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 edgeOut after reset", edgeOut, 1'b0);
    chk("R8 validOut after reset", validOut, 1'b0);
    rst = 1'b0;
    sendPix(64'h0000_0000_0000_0020, '0, "R8 zero tree N bit5 set");
    sendPix(64'hFFFF_FFFF_FFFF_FFDF, '0, "R8 zero tree N bit5 clear");
  endtask

  task automatic t_random;
    for (int r = 0; r < 4; r++) begin
      logic [GW-1:0] g;
      for (int i = 0; i < GW; i++) begin seed = xs(seed); g[i] = seed[0]; end
      loadGeno(g);
      for (int p = 0; p < 16; p++) begin
        logic [63:0] px;
        seed = xs(seed); px[31:0] = seed;
        seed = xs(seed); px[63:32] = seed;
        sendPix(px, g, "R1 R2 R3 R4 random tree");
      end
    end
  endtask

  task automatic t_not_root;
    logic [GW-1:0] g;
    g = mkGeno(2'b01, 5'b00_100);
    g[1:0] = 2'b10;
    for (int j = 0; j < 8; j++) g[30 + 5*j +: 5] = 5'b00_000;
    loadGeno(g);
    sendPix(64'h0000_0000_0000_0020, g, "R1 NOT root, N set");
    chk("R1 NOT root value", edgeOut, 1'b0);
    sendPix(64'h0000_0020_0000_0000, g, "R1 NOT ignores right, S set");
    chk("R1 NOT root value right", edgeOut, 1'b1);
  endtask

  task automatic t_wrap;
    logic [GW-1:0] g;
    g = mkGeno(2'b01, 5'b11_010);
    loadGeno(g);
    sendPix(64'h0000_0000_0020_0000, g, "R10 sel3 reads bit5");
    chk("R10 sel3 bit5 set", edgeOut, 1'b1);
    sendPix(64'h0000_0000_00C0_0000, g, "R10 sel3 ignores bits 7,6");
    chk("R10 sel3 bit5 clear", edgeOut, 1'b0);
    g = mkGeno(2'b01, 5'b10_010);
    loadGeno(g);
    sendPix(64'h0000_0000_0080_0000, g, "R3 sel2 reads bit7");
    chk("R3 sel2 bit7", edgeOut, 1'b1);
  endtask

  task automatic t_hold;
    logic [GW-1:0] g;
    g = mkGeno(2'b01, 5'b10_111);
    loadGeno(g);
    sendPix(64'h8000_0000_0000_0000, g, "R7 setup");
    @(negedge clk); validIn = 1'b0; nbPix = '0;
    @(negedge clk);
    chk("R7 edgeOut held", edgeOut, 1'b1);
    chk("R7 validOut low", validOut, 1'b0);
  endtask

  task automatic t_load_overlap;
    logic [GW-1:0] gA, gB;
    logic [63:0] px;
    gA = mkGeno(2'b01, 5'b10_111);
    gB = '0;
    px = 64'h8000_0000_0000_0000;
    loadGeno(gA);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); loadEn = 1'b1; loadBit = 1'b1;
    end
    for (int i = 0; i < GW; i++) begin
      @(negedge clk);
      if (i == 51) begin
        chk("R9 mid-load uses old tree", edgeOut, refTree(gA, px));
        chk("R9 mid-load validOut", validOut, 1'b1);
        validIn = 1'b0;
      end
      loadEn = 1'b1; loadBit = gB[i];
      if (i == 50) begin validIn = 1'b1; nbPix = px; end
    end
    @(negedge clk); loadEn = 1'b0; loadBit = 1'b0; validIn = 1'b1; nbPix = px;
    @(negedge clk);
    chk("R5 commit edge uses old tree", edgeOut, refTree(gA, px));
    @(negedge clk); validIn = 1'b0;
    chk("R5 R4 next edge uses new tree", edgeOut, refTree(gB, px));
    chk("R4 surplus bits dropped", edgeOut, 1'b0);
  endtask

  initial begin
    t_reset();
    t_random();
    t_not_root();
    t_wrap();
    t_hold();
    t_load_overlap();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 reset clears outputs", validOut, 1'b0);
    sendPix(64'h8000_0000_0000_0020, '0, "R8 genotype cleared by reset");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule